// File: doc/BRIEF.md
# Transmit Elastic Bit Store

This block sits between the system-side PCM stream and the line-side transmitter of a T1/J1 transmit path. System bits enter one per cycle in which the system bit strobe is high; line bits leave one per cycle in which the line bit strobe is high. Both strobes belong to one shared fast clock, so the two data rates may differ without any clock-domain crossing inside the block. The store absorbs the wander and jitter between the two rates up to its depth.

A two-bit size select chooses one of four modes: a straight pass-through, a one-frame store of 193 bits, a two-frame store of 386 bits, or a short store of 96 bits. Software sets the starting fill (the distance from the read pointer to the write pointer) by writing an offset. When the store runs dry or runs full, the block performs a controlled slip. It moves the read pointer so that the fill becomes the mode's re-centring distance, pulses a slip output for one cycle, records whether the slip came from overflow or underflow, and sets a sticky flag that stays set until it is cleared.

Top module: `tx_elastic_store`

## Requirements
- R1: On synchronous active-low reset, slip_pulse, slip_dir, slip_sticky and line_bit are 0, the whole store reads 0, the read pointer is at 0, and the fill equals the re-centring distance of the mode on size_sel.
- R2: With size_sel = 00 (pass-through), line_bit equals sys_bit in the same cycle, combinationally. Both strobes have no effect, and no slip is ever reported.
- R3: With size_sel = 01, 10 or 11 and both strobes high every cycle, the value on line_bit after the clock edge of a line strobe is the bit written F system strobes earlier, where F is the loaded fill. Pointers wrap modulo 193, 386 or 96 respectively, and no slip occurs.
- R4: An offset_wr pulse loads the fill from offset, clamped to one less than the active length, and puts the read pointer at 0.
- R5: A change of size_sel without offset_wr loads the fill with the new mode's re-centring distance.
- R6: In a cycle in which a load (R4 or R5) takes place, both strobes are ignored, and any pending slip condition is dropped.
- R7: A line strobe while the fill is 0 is an underflow: it causes a slip with slip_dir = 0.
- R8: A system strobe while the fill equals the active length is an overflow: it causes a slip with slip_dir = 1. slip_dir holds its value until the next slip.
- R9: After a slip, the fill is 96 in mode 01, 193 in mode 10 and 48 in mode 11.
- R10: slip_pulse goes high for exactly one cycle, registered on the same clock edge as the strobe that caused the slip.
- R11: slip_sticky is set by every slip and cleared only by slip_clr. A slip in the same cycle as slip_clr leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common fast clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| size_sel | input | 2 | 00 pass-through, 01 one frame, 10 two frames, 11 short |
| offset | input | 9 | Starting fill to load |
| offset_wr | input | 1 | Load strobe for offset |
| sys_bit_en | input | 1 | System-side bit strobe (write) |
| sys_bit | input | 1 | System-side data bit |
| line_bit_en | input | 1 | Line-side bit strobe (read) |
| line_bit | output | 1 | Line-side data bit |
| slip_clr | input | 1 | Clears the sticky slip flag |
| slip_pulse | output | 1 | One-cycle slip indication |
| slip_dir | output | 1 | Direction of the last slip, 1 overflow, 0 underflow |
| slip_sticky | output | 1 | Sticky slip interrupt flag |

## Verification
The bench counts the strobes from a load to the first slip, and then from that slip to the next. This exposes an off-by-one in the full or empty test, and a re-centring distance taken from the wrong mode: either one changes a count such as 4 then 49 for the short store. Steady-state runs that go past one full wrap compare each line bit against the bit written exactly F strobes before. A pointer that wraps at a power of two, or an offset that is not clamped, shows up there as wrong data. Directed cases cover a clear that arrives in the same cycle as a slip (a design where the clear wins would lose the interrupt), strobes in the cycle of a size change (a design that honours them would be off by one in the next count), and pass-through with strobes running (a design that still moves its pointers would raise spurious slips).

// File: rtl/tx_es_pkg.sv
// Package: shared mode encoding for the transmit elastic bit store.
// Assumes the encoding is fixed by the size-select input field.
package tx_es_pkg;

    typedef enum logic [1:0] {
        ES_BYPASS = 2'b00,
        ES_ONE    = 2'b01,
        ES_TWO    = 2'b10,
        ES_SHORT  = 2'b11
    } es_mode_e;

endpackage

// File: rtl/tx_es_mode_geom.sv
// Module: tx_es_mode_geom
// Turns the mode code into the active store length, the fill to restore
// after a slip, and a pass-through flag. Pure combinational logic.
// Assumes PTR_W can hold 2*FRAME_BITS.
module tx_es_mode_geom
    import tx_es_pkg::*;
#(
    parameter int FRAME_BITS = 193,
    parameter int SHORT_BITS = 96,
    parameter int PTR_W      = $clog2(2 * FRAME_BITS + 1)
) (
    input  es_mode_e         mode,
    output logic [PTR_W-1:0] len,
    output logic [PTR_W-1:0] centre,
    output logic             bypass
);

    localparam logic [PTR_W-1:0] LEN_ONE   = PTR_W'(FRAME_BITS);
    localparam logic [PTR_W-1:0] LEN_TWO   = PTR_W'(2 * FRAME_BITS);
    localparam logic [PTR_W-1:0] LEN_SHORT = PTR_W'(SHORT_BITS);
    localparam logic [PTR_W-1:0] CTR_ONE   = PTR_W'(FRAME_BITS / 2);
    localparam logic [PTR_W-1:0] CTR_TWO   = PTR_W'(FRAME_BITS);
    localparam logic [PTR_W-1:0] CTR_SHORT = PTR_W'(SHORT_BITS / 2);

    // Decode length and re-centring distance per mode.
    always_comb begin
        bypass = 1'b0;
        case (mode)
            ES_ONE:   begin len = LEN_ONE;   centre = CTR_ONE;   end
            ES_TWO:   begin len = LEN_TWO;   centre = CTR_TWO;   end
            ES_SHORT: begin len = LEN_SHORT; centre = CTR_SHORT; end
            default:  begin len = LEN_ONE;   centre = CTR_ONE;   bypass = 1'b1; end
        endcase
    end

endmodule

// File: rtl/tx_es_ptr_ctrl.sv
// Module: tx_es_ptr_ctrl
// Keeps the write pointer, the read pointer and the fill level, all
// wrapping modulo the active length. Detects overflow and underflow and
// re-centres the read pointer on a slip. A load takes priority over
// strobes. Assumes 0 < centre < len and sep < len.
module tx_es_ptr_ctrl #(
    parameter int PTR_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] sep,
    input  logic [PTR_W-1:0] len,
    input  logic [PTR_W-1:0] centre,
    input  logic             bypass,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             wr_act,
    output logic             rd_act,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] level,
    output logic             slip_evt,
    output logic             slip_ovf
);

    logic             ovf, unf;
    logic [PTR_W-1:0] last_idx;
    logic [PTR_W-1:0] wr_inc, rd_inc, wr_nxt, rd_nxt, rd_rc;
    logic [PTR_W-1:0] level_nxt, gap;

    // Qualify strobes: ignored in pass-through and during a load.
    always_comb begin
        wr_act = wr_en & ~bypass & ~load;
        rd_act = rd_en & ~bypass & ~load;
    end

    // Slip detection from the fill seen before this cycle's strobes.
    always_comb begin
        ovf      = wr_act && (level == len);
        unf      = rd_act && (level == '0);
        slip_evt = ovf | unf;
        slip_ovf = ovf;
    end

    // Modulo-length pointer increments.
    always_comb begin
        last_idx = len - PTR_W'(1);
        wr_inc   = (wr_ptr == last_idx) ? '0 : wr_ptr + PTR_W'(1);
        rd_inc   = (rd_ptr == last_idx) ? '0 : rd_ptr + PTR_W'(1);
        wr_nxt   = wr_act ? wr_inc : wr_ptr;
        rd_nxt   = rd_act ? rd_inc : rd_ptr;
    end

    // Re-centred read pointer: write pointer minus centre, modulo len.
    always_comb begin
        gap   = len - centre;
        rd_rc = (wr_nxt >= centre) ? (wr_nxt - centre) : (wr_nxt + gap);
    end

    // Fill update for an ordinary cycle.
    always_comb begin
        case ({wr_act, rd_act})
            2'b10:   level_nxt = level + PTR_W'(1);
            2'b01:   level_nxt = level - PTR_W'(1);
            default: level_nxt = level;
        endcase
    end

    // Pointer and fill registers with reset, load and slip handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= centre;
            level  <= centre;
        end else if (load) begin
            rd_ptr <= '0;
            wr_ptr <= sep;
            level  <= sep;
        end else if (slip_evt) begin
            wr_ptr <= wr_nxt;
            rd_ptr <= rd_rc;
            level  <= centre;
        end else begin
            wr_ptr <= wr_nxt;
            rd_ptr <= rd_nxt;
            level  <= level_nxt;
        end
    end

endmodule

// File: rtl/tx_es_store.sv
// Module: tx_es_store
// Bit array of DEPTH cells with one write port and one registered read
// port. Cleared by reset. Assumes the addresses stay below DEPTH.
module tx_es_store #(
    parameter int DEPTH = 386,
    parameter int PTR_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic             wr_bit,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] rd_addr,
    output logic             rd_bit
);

    logic [DEPTH-1:0] cells;

    // One register per cell, written when the address matches.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[g] <= 1'b0;
            else if (wr_en && (wr_addr == PTR_W'(g)))
                cells[g] <= wr_bit;
        end
    end

    // Registered read of the addressed cell on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_bit <= 1'b0;
        else if (rd_en)
            rd_bit <= cells[rd_addr];
    end

endmodule

// File: rtl/tx_es_slip_flag.sv
// Module: tx_es_slip_flag
// Registers the slip indications: a one-cycle pulse, the direction of
// the latest slip, and a sticky flag where a set wins over a clear.
module tx_es_slip_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic ovf,
    input  logic clr,
    output logic pulse,
    output logic dir,
    output logic sticky
);

    // Pulse, direction and sticky flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse  <= 1'b0;
            dir    <= 1'b0;
            sticky <= 1'b0;
        end else begin
            pulse <= evt;
            if (evt)
                dir <= ovf;
            if (evt)
                sticky <= 1'b1;
            else if (clr)
                sticky <= 1'b0;
        end
    end

endmodule

// File: rtl/tx_elastic_store.sv
// Module: tx_elastic_store (top)
// Bit-serial transmit elastic store with four size modes, a programmable
// starting fill and controlled slips. Both sides share clk and are
// paced by their own bit strobes. Assumes FRAME_BITS > SHORT_BITS > 1.
module tx_elastic_store
    import tx_es_pkg::*;
#(
    parameter int FRAME_BITS = 193,
    parameter int SHORT_BITS = 96
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] size_sel,
    input  logic [8:0] offset,
    input  logic       offset_wr,
    input  logic       sys_bit_en,
    input  logic       sys_bit,
    input  logic       line_bit_en,
    output logic       line_bit,
    input  logic       slip_clr,
    output logic       slip_pulse,
    output logic       slip_dir,
    output logic       slip_sticky
);

    localparam int DEPTH = 2 * FRAME_BITS;
    localparam int PTR_W = $clog2(DEPTH + 1);

    es_mode_e         mode_w;
    logic [1:0]       size_q;
    logic             load_w, bypass_w, wr_act_w, rd_act_w;
    logic [PTR_W-1:0] len_w, centre_w, sep_w, off_w, level_w;
    logic [PTR_W-1:0] wr_ptr_w, rd_ptr_w;
    logic             rd_bit_w, slip_evt_w, slip_ovf_w;

    assign mode_w = es_mode_e'(size_sel);

    // Remember the mode in force so that a change can trigger a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            size_q <= size_sel;
        else
            size_q <= size_sel;
    end

    // A load comes from an offset write or a mode change.
    always_comb begin
        load_w = offset_wr | (size_sel != size_q);
    end

    // Choose the starting fill: a clamped offset or the mode centre.
    always_comb begin
        off_w = PTR_W'(offset);
        if (offset_wr)
            sep_w = (off_w >= len_w) ? (len_w - PTR_W'(1)) : off_w;
        else
            sep_w = centre_w;
    end

    tx_es_mode_geom #(
        .FRAME_BITS (FRAME_BITS),
        .SHORT_BITS (SHORT_BITS),
        .PTR_W      (PTR_W)
    ) u_geom (
        .mode   (mode_w),
        .len    (len_w),
        .centre (centre_w),
        .bypass (bypass_w)
    );

    tx_es_ptr_ctrl #(
        .PTR_W (PTR_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_w),
        .sep      (sep_w),
        .len      (len_w),
        .centre   (centre_w),
        .bypass   (bypass_w),
        .wr_en    (sys_bit_en),
        .rd_en    (line_bit_en),
        .wr_act   (wr_act_w),
        .rd_act   (rd_act_w),
        .wr_ptr   (wr_ptr_w),
        .rd_ptr   (rd_ptr_w),
        .level    (level_w),
        .slip_evt (slip_evt_w),
        .slip_ovf (slip_ovf_w)
    );

    tx_es_store #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_act_w),
        .wr_addr (wr_ptr_w),
        .wr_bit  (sys_bit),
        .rd_en   (rd_act_w),
        .rd_addr (rd_ptr_w),
        .rd_bit  (rd_bit_w)
    );

    tx_es_slip_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (slip_evt_w),
        .ovf    (slip_ovf_w),
        .clr    (slip_clr),
        .pulse  (slip_pulse),
        .dir    (slip_dir),
        .sticky (slip_sticky)
    );

    // Line output: direct pass-through or the registered store output.
    always_comb begin
        line_bit = bypass_w ? sys_bit : rd_bit_w;
    end

endmodule

// File: rtl/tx_es_checker.sv
// Module: tx_es_checker
// Concurrent checks on the slip outputs and the fill level of
// tx_elastic_store. Attached to the top module through the bind below.
module tx_es_checker #(
    parameter int PTR_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       size_sel,
    input logic             slip_clr,
    input logic             slip_pulse,
    input logic             slip_dir,
    input logic             slip_sticky,
    input logic [PTR_W-1:0] level,
    input logic [PTR_W-1:0] len,
    input logic [PTR_W-1:0] centre
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        slip_pulse |=> !slip_pulse); // R10

    AST_STICKY_ON_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
        slip_pulse |-> slip_sticky); // R11

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_sticky && !slip_clr) |=> slip_sticky); // R11

    AST_BYPASS_NO_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (size_sel == 2'b00) |=> !slip_pulse); // R2

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(size_sel) |-> (level <= len)); // R3

    AST_RECENTRE_DIST: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_pulse && $stable(size_sel)) |-> (level == centre)); // R9

    AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !slip_pulse |-> $stable(slip_dir)); // R8

endmodule

bind tx_elastic_store tx_es_checker #(.PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .size_sel    (size_sel),
    .slip_clr    (slip_clr),
    .slip_pulse  (slip_pulse),
    .slip_dir    (slip_dir),
    .slip_sticky (slip_sticky),
    .level       (level_w),
    .len         (len_w),
    .centre      (centre_w)
);

// File: tb/tx_elastic_store_tb_top.sv
module tx_elastic_store_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] size_sel = 2'b01;
    logic [8:0] offset = '0;
    logic       offset_wr = 1'b0;
    logic       sys_bit_en = 1'b0;
    logic       sys_bit = 1'b0;
    logic       line_bit_en = 1'b0;
    logic       line_bit;
    logic       slip_clr = 1'b0;
    logic       slip_pulse, slip_dir, slip_sticky;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    logic wrote [0:1023];

    // Vector: {mode[1:0], offset[8:0], expected fill[8:0]}
    localparam logic [19:0] VEC [0:5] = '{
        {2'b01, 9'd50,  9'd50},
        {2'b10, 9'd300, 9'd300},
        {2'b11, 9'd20,  9'd20},
        {2'b01, 9'd250, 9'd192},
        {2'b11, 9'd200, 9'd95},
        {2'b10, 9'd385, 9'd385}
    };

    always #2 clk = ~clk;

    tx_elastic_store dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .size_sel    (size_sel),
        .offset      (offset),
        .offset_wr   (offset_wr),
        .sys_bit_en  (sys_bit_en),
        .sys_bit     (sys_bit),
        .line_bit_en (line_bit_en),
        .line_bit    (line_bit),
        .slip_clr    (slip_clr),
        .slip_pulse  (slip_pulse),
        .slip_dir    (slip_dir),
        .slip_sticky (slip_sticky)
    );

    function automatic logic bf(input int k);
        int t;
        t = k * k + 3 * k + (k >>> 3);
        return t[4] ^ t[1];
    endfunction

    function automatic int mode_len(input logic [1:0] m);
        case (m)
            2'b10:   return 386;
            2'b11:   return 96;
            default: return 193;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic w, input logic r, input logic b, input logic clr);
        @(negedge clk);
        sys_bit_en = w; line_bit_en = r; sys_bit = b; slip_clr = clr;
        @(posedge clk); #1;
    endtask

    task automatic load_cfg(input logic [1:0] m, input logic [8:0] off, input logic wr);
        @(negedge clk);
        size_sel = m; offset = off; offset_wr = wr;
        sys_bit_en = 0; line_bit_en = 0; slip_clr = 0;
        @(posedge clk); #1;
        offset_wr = 0;
    endtask

    // Strobes until slip_pulse appears; returns the count, or -1.
    task automatic until_slip(input logic w, input logic r, input int maxn, output int n);
        n = -1;
        for (int i = 1; i <= maxn; i++) begin
            tick(w, r, 1'b0, 1'b0);
            if (slip_pulse) begin
                n = i;
                return;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int n, bad_z, bad_d, len, fill;
        logic [19:0] v;

        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset outputs
        chk({slip_pulse, slip_dir, slip_sticky, line_bit} == 4'b0, "R1 reset outputs",
            {slip_pulse, slip_dir, slip_sticky, line_bit}, 0);

        // R1 fill after reset equals 96 in mode 01; store cleared
        bad_z = 0; bad_d = 0;
        for (int k = 0; k < 140; k++) begin
            wrote[k] = bf(k);
            tick(1'b1, 1'b1, wrote[k], 1'b0);
            if (k < 96 && line_bit !== 1'b0) bad_z++;
            if (k >= 96 && line_bit !== wrote[k - 96]) bad_d++;
        end
        chk(bad_z == 0, "R1 cleared store", bad_z, 0);
        chk(bad_d == 0, "R1 centre fill after reset", bad_d, 0);

        // R3 / R4 steady-state delay table, past a full wrap
        for (int vi = 0; vi < 6; vi++) begin
            v = VEC[vi];
            len = mode_len(v[19:18]);
            fill = int'(v[8:0]);
            load_cfg(v[19:18], v[17:9], 1'b1);
            tick(1'b0, 1'b0, 1'b0, 1'b1);
            bad_d = 0;
            for (int k = 0; k < len + fill + 30; k++) begin
                wrote[k] = bf(k);
                tick(1'b1, 1'b1, wrote[k], 1'b0);
                if (k >= len && line_bit !== wrote[k - fill]) bad_d++;
            end
            chk(bad_d == 0, "R3 R4 delay equals loaded fill", bad_d, 0);
            chk(slip_sticky == 1'b0, "R3 no slip in steady state", slip_sticky, 0);
        end

        // R7 / R9 short store: offset 3 then underflow, re-centre to 48
        load_cfg(2'b11, 9'd3, 1'b1);
        until_slip(1'b0, 1'b1, 200, n);
        chk(n == 4, "R7 reads to underflow", n, 4);
        chk(slip_dir == 1'b0, "R7 underflow direction", slip_dir, 0);
        chk(slip_sticky == 1'b1, "R11 sticky set", slip_sticky, 1);
        tick(1'b0, 1'b0, 1'b0, 1'b0);
        chk(slip_pulse == 1'b0, "R10 pulse lasts one cycle", slip_pulse, 0);
        until_slip(1'b0, 1'b1, 200, n);
        chk(n == 49, "R9 short re-centre 48", n, 49);

        // R11 clear
        tick(1'b0, 1'b0, 1'b0, 1'b1);
        chk(slip_sticky == 1'b0, "R11 sticky cleared", slip_sticky, 0);

        // R8 / R9 one-frame store: overflow then re-centre to 96
        load_cfg(2'b01, 9'd190, 1'b1);
        until_slip(1'b1, 1'b0, 400, n);
        chk(n == 4, "R8 writes to overflow", n, 4);
        chk(slip_dir == 1'b1, "R8 overflow direction", slip_dir, 1);
        until_slip(1'b0, 1'b1, 400, n);
        chk(n == 97, "R9 one-frame re-centre 96", n, 97);
        chk(slip_dir == 1'b0, "R8 direction follows latest slip", slip_dir, 0);

        // R9 two-frame store: re-centre to 193
        load_cfg(2'b10, 9'd1, 1'b1);
        until_slip(1'b0, 1'b1, 400, n);
        chk(n == 2, "R7 two-frame reads to underflow", n, 2);
        until_slip(1'b0, 1'b1, 400, n);
        chk(n == 194, "R9 two-frame re-centre 193", n, 194);

        // R5 / R6 size change alone loads centre; strobe in that cycle ignored
        @(negedge clk);
        size_sel = 2'b11; line_bit_en = 1'b1; sys_bit_en = 1'b0;
        @(posedge clk); #1;
        chk(slip_pulse == 1'b0, "R6 no slip on load cycle", slip_pulse, 0);
        until_slip(1'b0, 1'b1, 200, n);
        chk(n == 49, "R5 R6 size change fill 48", n, 49);

        // R11 slip together with clear leaves sticky set
        load_cfg(2'b11, 9'd0, 1'b1);
        tick(1'b0, 1'b1, 1'b0, 1'b1);
        chk(slip_pulse == 1'b1, "R7 empty read slips", slip_pulse, 1);
        chk(slip_sticky == 1'b1, "R11 set wins over clear", slip_sticky, 1);

        // R2 pass-through
        load_cfg(2'b00, 9'd0, 1'b0);
        tick(1'b0, 1'b0, 1'b0, 1'b1);
        bad_d = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sys_bit = i[0] ^ i[2]; sys_bit_en = 1'b1; line_bit_en = 1'b1;
            #1;
            if (line_bit !== (i[0] ^ i[2])) bad_d++;
        end
        chk(bad_d == 0, "R2 line follows system bit", bad_d, 0);
        n = 0;
        for (int k = 0; k < 500; k++) begin
            tick(1'b1, k[0], bf(k), 1'b0);
            if (slip_pulse) n++;
        end
        chk(n == 0 && slip_sticky == 1'b0, "R2 no slips in pass-through", n, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule